// File: doc/BRIEF.md
# Converter Host Bus Interface

This block is the host-facing control logic of a parallel-output analog-to-digital converter. It takes the slow, asynchronous control pins from a processor bus, brings them into the converter clock domain and decodes them. A conversion is requested when the chip enable is high, the active-low select is low and the read/convert line is low. The block raises a one-cycle start strobe for the conversion sequencer on whichever of those three lines completes the request last. At that instant it also captures the address line, which selects between a short 8-bit conversion and a full 12-bit one.

On the read side the block keeps the last finished result. It drives it onto a 12-bit data bus with one output enable per line, which stand in for three-state drivers. The result is shown either as one whole word or, for an 8-bit bus, as two left-justified bytes. In byte mode the address line picks the byte, and the lower byte is padded with zeros. The sequencer feeds back a busy level and a done pulse with the result. For stand-alone use the board ties the enable, select, address and word-mode lines to fixed levels, so that the read/convert line alone starts conversions and reads data.

Top module: `cnv_host_if`

## Requirements
- R1: A start condition is chip enable high, select low and read/convert low at once. After a two-stage synchronizer, `start_o` pulses for exactly one clock per rising edge of that condition, whichever of the three lines changed last. The pulse appears in the second clock after the input change.
- R2: On each rising edge of the start condition, the synchronized address level is captured into `short_cycle_o`, where 1 means an 8-bit conversion and 0 a 12-bit one. No other input changes `short_cycle_o`, and address changes without such an edge leave it unchanged.
- R3: While `busy_i` is high, `start_o` stays low. A start edge during busy still re-captures the address into `short_cycle_o`.
- R4: Lines are enabled only while read/convert is high, `busy_i` is low, chip enable is high and select is low, all synchronized. Otherwise `data_oe_o` is all zero and `data_o` is all zero.
- R5: With the word-mode line high during a read, all 12 enables are set, `data_o` equals the stored result, and the address line has no effect.
- R6: With word mode low and address low during a read, lines 11..4 carry result bits 11..4, with enables on lines 11..4 only.
- R7: With word mode low and address high during a read, lines 11..8 carry result bits 3..0 and lines 7..4 carry forced zeros, with enables on lines 11..4 only.
- R8: With chip enable and word mode tied high and select and address tied low, a falling read/convert edge gives one start with `short_cycle_o` = 0, and a high read/convert presents the full word.
- R9: Toggling the address during a byte-mode read never enables lines 3..0; the enable pattern is only ever all-off or lines 11..4.
- R10: The stored result is loaded from `result_i` only in a clock where `done_i` is high, and it is held unchanged otherwise.
- R11: During and right after reset, `start_o`, `short_cycle_o` and all enables are 0 and the stored result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_i | input | 1 | Chip enable, active high, asynchronous |
| sel_n_i | input | 1 | Chip select, active low, asynchronous |
| rdconv_i | input | 1 | 1 = read, 0 = convert, asynchronous |
| addr0_i | input | 1 | Short-cycle select at start, byte select on read |
| full_word_i | input | 1 | 1 = whole word read, 0 = two-byte read |
| busy_i | input | 1 | Conversion in progress, from sequencer |
| done_i | input | 1 | One-cycle result valid pulse from sequencer |
| result_i | input | 12 | Finished conversion result |
| start_o | output | 1 | One-cycle conversion start strobe |
| short_cycle_o | output | 1 | Captured length select, 1 = 8-bit |
| data_o | output | 12 | Output data lines |
| data_oe_o | output | 12 | Per-line output enables |

## Verification
The bench makes each of the three control lines the last one to complete a start request, and counts strobes. A detector that watched only one line, or fired on a level, would miss a start or give several. It starts a conversion while busy with a different address, so a design that dropped the re-capture, or let the strobe through, shows the wrong length or an extra start. Both byte formats are read. Toggling the address during a byte read catches swapped halves, missing zero padding and enables leaking onto the low lines. The stored result is fed different values with and without the done pulse, which shows any load outside that pulse.

// File: rtl/cnvif_pkg.sv
package cnvif_pkg;

    localparam int RES_W_DEF  = 12;
    localparam int BYTE_W_DEF = 8;
    localparam int SYNC_N_DEF = 2;

    // synchronized host control levels
    typedef struct packed {
        logic ce;
        logic sel_n;
        logic rdconv;
        logic addr0;
        logic full_word;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    // idle bus: deselected, read level, word mode
    localparam ctl_t CTL_IDLE = '{ce: 1'b0, sel_n: 1'b1, rdconv: 1'b1,
                                  addr0: 1'b0, full_word: 1'b1};

    typedef enum logic [1:0] {
        FMT_OFF  = 2'd0,
        FMT_WORD = 2'd1,
        FMT_HIGH = 2'd2,
        FMT_LOW  = 2'd3
    } rd_fmt_e;

    function automatic logic start_cond(input ctl_t c);
        return c.ce & ~c.sel_n & ~c.rdconv;
    endfunction

    function automatic logic read_open(input ctl_t c, input logic busy);
        return c.ce & ~c.sel_n & c.rdconv & ~busy;
    endfunction

    function automatic rd_fmt_e pick_fmt(input ctl_t c, input logic busy);
        rd_fmt_e f;
        if (!read_open(c, busy))  f = FMT_OFF;
        else if (c.full_word)     f = FMT_WORD;
        else if (c.addr0)         f = FMT_LOW;
        else                      f = FMT_HIGH;
        return f;
    endfunction

endpackage

// File: rtl/cnvif_sync.sv
module cnvif_sync #(
    parameter int             W      = 1,
    parameter int             STAGES = 2,
    parameter logic [W-1:0]   RST_V  = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_V;
        end else begin
            stg[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q_o = stg[STAGES-1];

endmodule

// File: rtl/cnvif_start_det.sv
module cnvif_start_det
    import cnvif_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ctl_t ctl_i,
    input  logic busy_i,
    output logic start_o,
    output logic short_o
);
    logic cond_q;
    logic short_q;
    logic rise_w;

    assign rise_w = start_cond(ctl_i) & ~cond_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cond_q  <= 1'b0;
            short_q <= 1'b0;
        end else begin
            cond_q <= start_cond(ctl_i);
            if (rise_w) short_q <= ctl_i.addr0;
        end
    end

    assign start_o = rise_w & ~busy_i;
    assign short_o = short_q;

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
        start_o |=> !start_o);                                   // R1
    AST_SHORT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(rise_w) |-> $stable(short_q));                    // R2

endmodule

// File: rtl/cnvif_read_path.sv
module cnvif_read_path
    import cnvif_pkg::*;
#(
    parameter int RES_W  = RES_W_DEF,
    parameter int BYTE_W = BYTE_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  ctl_t             ctl_i,
    input  logic             busy_i,
    input  logic             done_i,
    input  logic [RES_W-1:0] result_i,
    output logic [RES_W-1:0] data_o,
    output logic [RES_W-1:0] oe_o
);
    localparam int HI_LSB = RES_W - BYTE_W;   // lowest line of the byte lane
    localparam int LOW_W  = RES_W - BYTE_W;   // bits carried by the low byte
    localparam int PAD_W  = BYTE_W - LOW_W;   // forced zero lines

    logic [RES_W-1:0] result_q;
    rd_fmt_e          fmt;

    always_ff @(posedge clk) begin
        if (rst)         result_q <= '0;
        else if (done_i) result_q <= result_i;
    end

    assign fmt = pick_fmt(ctl_i, busy_i);

    always_comb begin
        data_o = '0;
        oe_o   = '0;
        unique case (fmt)
            FMT_WORD: begin
                data_o = result_q;
                oe_o   = '1;
            end
            FMT_HIGH: begin
                data_o[RES_W-1:HI_LSB] = result_q[RES_W-1:HI_LSB];
                oe_o[RES_W-1:HI_LSB]   = '1;
            end
            FMT_LOW: begin
                data_o[RES_W-1 -: LOW_W] = result_q[LOW_W-1:0];
                oe_o[RES_W-1:HI_LSB]     = '1;
            end
            default: begin
                data_o = '0;
                oe_o   = '0;
            end
        endcase
    end

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(done_i) |-> $stable(result_q));                   // R10
    AST_LOW_LINES_OFF: assert property (@(posedge clk) disable iff (rst)
        (oe_o != '0 && !ctl_i.full_word) |-> (oe_o[HI_LSB-1:0] == '0)); // R9
    AST_WORD_ALL_ON: assert property (@(posedge clk) disable iff (rst)
        (oe_o != '0 && ctl_i.full_word) |-> (&oe_o));            // R5
    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (oe_o != '0 && !ctl_i.full_word && ctl_i.addr0)
            |-> (data_o[HI_LSB +: PAD_W] == '0));                // R7

endmodule

// File: rtl/cnv_host_if.sv
module cnv_host_if
    import cnvif_pkg::*;
#(
    parameter int RES_W  = RES_W_DEF,
    parameter int BYTE_W = BYTE_W_DEF,
    parameter int SYNC_N = SYNC_N_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce_i,
    input  logic             sel_n_i,
    input  logic             rdconv_i,
    input  logic             addr0_i,
    input  logic             full_word_i,
    input  logic             busy_i,
    input  logic             done_i,
    input  logic [RES_W-1:0] result_i,
    output logic             start_o,
    output logic             short_cycle_o,
    output logic [RES_W-1:0] data_o,
    output logic [RES_W-1:0] data_oe_o
);
    ctl_t raw_ctl;
    ctl_t sync_ctl;
    logic [CTL_W-1:0] sync_bits;

    assign raw_ctl = '{ce: ce_i, sel_n: sel_n_i, rdconv: rdconv_i,
                       addr0: addr0_i, full_word: full_word_i};

    cnvif_sync #(
        .W      (CTL_W),
        .STAGES (SYNC_N),
        .RST_V  (CTL_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_ctl),
        .q_o (sync_bits)
    );

    assign sync_ctl = ctl_t'(sync_bits);

    cnvif_start_det u_start (
        .clk     (clk),
        .rst     (rst),
        .ctl_i   (sync_ctl),
        .busy_i  (busy_i),
        .start_o (start_o),
        .short_o (short_cycle_o)
    );

    cnvif_read_path #(
        .RES_W  (RES_W),
        .BYTE_W (BYTE_W)
    ) u_read (
        .clk      (clk),
        .rst      (rst),
        .ctl_i    (sync_ctl),
        .busy_i   (busy_i),
        .done_i   (done_i),
        .result_i (result_i),
        .data_o   (data_o),
        .oe_o     (data_oe_o)
    );

    AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy_i |-> !start_o);                                    // R3
    AST_HIZ_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy_i |-> (data_oe_o == '0));                           // R4
    AST_HIZ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (data_oe_o == '0) |-> (data_o == '0));                   // R4

endmodule

// File: tb/sim_cnv_host_if.sv
module sim_cnv_host_if;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce = 1'b0, sel_n = 1'b1, rc = 1'b1, a0 = 1'b0, fw = 1'b1;
    logic        busy = 1'b0, done = 1'b0;
    logic [11:0] result = '0;
    logic        start_o, short_o;
    logic [11:0] data_o, oe_o;

    int checks = 0;
    int fails  = 0;
    int starts = 0;

    always #10 clk = ~clk;   // 50 MHz

    cnv_host_if u0 (
        .clk (clk), .rst (rst), .ce_i (ce), .sel_n_i (sel_n), .rdconv_i (rc),
        .addr0_i (a0), .full_word_i (fw), .busy_i (busy), .done_i (done),
        .result_i (result), .start_o (start_o), .short_cycle_o (short_o),
        .data_o (data_o), .data_oe_o (oe_o)
    );

    always @(negedge clk) if (!rst && start_o) starts++;

    typedef struct packed {
        logic ce, sel_n, rc, a0, fw, busy;
        logic [11:0] oe;
        logic [11:0] data;
        logic [3:0]  req;
    } vec_t;

    // stored result 0xA5C while walking this table
    localparam vec_t VEC [8] = '{
        '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0, 12'hFFF, 12'hA5C, 4'd5}, // R5 word
        '{1'b1,1'b0,1'b1,1'b1,1'b1,1'b0, 12'hFFF, 12'hA5C, 4'd5}, // R5 A0 ignored
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 12'hFF0, 12'hA50, 4'd6}, // R6 high byte
        '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0, 12'hFF0, 12'hC00, 4'd7}, // R7 low byte
        '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0, 12'h000, 12'h000, 4'd4}, // R4 ce low
        '{1'b1,1'b1,1'b1,1'b0,1'b1,1'b0, 12'h000, 12'h000, 4'd4}, // R4 deselected
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, 12'h000, 12'h000, 4'd4}, // R4 convert level
        '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b1, 12'h000, 12'h000, 4'd4}  // R4 busy
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic c, input logic s, input logic r,
                         input logic a, input logic f, input logic b);
        @(negedge clk);
        ce = c; sel_n = s; rc = r; a0 = a; fw = f; busy = b;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic load(input logic [11:0] v);
        @(negedge clk);
        result = v; done = 1'b1;
        @(negedge clk);
        done = 1'b0;
        result = ~v;   // later changes without done must not load
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 start in reset", 32'(start_o), 0);
        chk("R11 short in reset", 32'(short_o), 0);
        chk("R11 oe in reset", 32'(oe_o), 0);
        @(negedge clk) rst = 1'b0;
        drive(1, 0, 1, 0, 1, 0);
        settle();
        chk("R11 result after reset", 32'(data_o), 0);

        // table walk on the read path
        load(12'hA5C);
        foreach (VEC[i]) begin
            drive(VEC[i].ce, VEC[i].sel_n, VEC[i].rc, VEC[i].a0, VEC[i].fw, VEC[i].busy);
            settle();
            chk($sformatf("R%0d oe vec%0d", VEC[i].req, i), 32'(oe_o), 32'(VEC[i].oe));
            chk($sformatf("R%0d data vec%0d", VEC[i].req, i), 32'(data_o), 32'(VEC[i].data));
        end

        // R1: chip enable completes the condition last, with latency
        begin
            int s0;
            drive(0, 0, 0, 1, 1, 0);
            settle();
            s0 = starts;
            drive(1, 0, 0, 1, 1, 0);
            @(negedge clk);
            chk("R1 no start after one clock", 32'(start_o), 0);
            @(negedge clk);
            chk("R1 start in second clock", 32'(start_o), 1);
            repeat (6) @(negedge clk);
            chk("R1 one pulse ce last", 32'(starts - s0), 1);
            chk("R2 short latched high", 32'(short_o), 1);
        end

        // R2: address change without a new edge leaves the length alone
        drive(1, 0, 0, 0, 0, 0);
        settle();
        chk("R2 short unchanged", 32'(short_o), 1);

        // R1: select last
        begin
            int s0;
            drive(1, 1, 0, 0, 1, 0);
            settle();
            s0 = starts;
            drive(1, 0, 0, 0, 1, 0);
            settle();
            chk("R1 one pulse sel last", 32'(starts - s0), 1);
            chk("R2 short latched low", 32'(short_o), 0);
        end

        // R1: read/convert last
        begin
            int s0;
            drive(1, 0, 1, 0, 1, 0);
            settle();
            s0 = starts;
            drive(1, 0, 0, 0, 1, 0);
            settle();
            chk("R1 one pulse rc last", 32'(starts - s0), 1);
        end

        // R3: start edge while busy re-latches the length only
        begin
            int s0;
            drive(1, 0, 1, 0, 1, 1);
            settle();
            s0 = starts;
            drive(1, 0, 0, 1, 1, 1);
            settle();
            chk("R3 no start while busy", 32'(starts - s0), 0);
            chk("R3 length re-latched", 32'(short_o), 1);
        end

        // R10: new result only with done
        drive(1, 0, 1, 0, 1, 0);
        load(12'h3C7);
        settle();
        chk("R10 loaded on done", 32'(data_o), 32'h3C7);
        @(negedge clk) result = 12'h111;
        settle();
        chk("R10 held without done", 32'(data_o), 32'h3C7);

        // R9: toggling the byte select during a byte read
        drive(1, 0, 1, 0, 0, 0);
        settle();
        for (int k = 0; k < 12; k++) begin
            @(negedge clk) a0 = ~a0;
            chk("R9 low lines off", 32'(oe_o[3:0]), 0);
            chk("R9 byte lane pattern", 32'(oe_o == 12'hFF0 || oe_o == 12'h000), 1);
        end

        // R8: stand-alone wiring, read/convert alone
        begin
            int s0;
            drive(1, 0, 1, 1, 1, 0);   // leave a0 high first so the latch must change
            drive(1, 0, 1, 0, 1, 0);
            settle();
            s0 = starts;
            drive(1, 0, 0, 0, 1, 0);
            settle();
            chk("R8 one start", 32'(starts - s0), 1);
            chk("R8 12-bit length", 32'(short_o), 0);
            load(12'h5E1);
            drive(1, 0, 1, 0, 1, 0);
            settle();
            chk("R8 full word oe", 32'(oe_o), 32'hFFF);
            chk("R8 full word data", 32'(data_o), 32'h5E1);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog run hung");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule